// File: doc/BRIEF.md
# Clock Synthesizer Configuration Watchdog with Safe-Frequency Fallback

This block guards the frequency-select setting of a programmable clock synthesizer. Software arms a down-counter through one 8-bit control register. If the counter runs out before software restarts it, the block raises a sticky timeout flag. In the same cycle it overwrites the live five-bit frequency-select output with a fallback code held in the same register. The system then drops back to a clock setting that is known to work.

The control register holds three fields. An enable/run bit starts or stops the countdown when written, and reads back whether the countdown is still in progress. A timeout flag can only be read. A five-bit safe code is stored for the fallback. Whether the countdown runs straight out of reset is not fixed: it comes from a strap input that is captured while the power-good-derived reset is asserted. The frequency-select output can also be written directly through its own strobe. The countdown advances only on cycles where a slow tick-enable input is high.

Top module: `safeclk_watchdog`

## Requirements
- R1: While `pwrRst` is high on a clock edge, the block takes its reset state. `regRdata` then reads `{1'b0, strapWdEn, 1'b0, 5'b00000}` and `fsOut` equals parameter `FS_INIT`. With the strap at 1, the countdown is loaded with `RELOAD` and starts.
- R2: A register write (`regWr`) with bit 6 set reloads the counter to `RELOAD` and starts it. From the next cycle, bit 6 reads 1 and bit 5 reads 0. This holds even if a timeout had happened earlier or a countdown was already in progress.
- R3: Once started, the countdown times out on the `RELOAD`-th cycle with `tick` high. After that edge, bit 6 reads 0 and bit 5 reads 1, changing together. Before that tick, bit 6 stays 1 and bit 5 stays 0.
- R4: On the timeout edge, `fsOut` takes the safe code, which is register bits 4:0 as last written.
- R5: A register write with bit 6 clear stops the countdown. Bit 6 reads 0 afterwards, and no timeout follows however many ticks arrive.
- R6: The value written to bit 5 has no effect. The flag is changed only by a restart or a timeout.
- R7: Register bit 7 always reads 0.
- R8: When no timeout occurs in a cycle, `fsWr` loads `fsWdata` into `fsOut` at the next edge.
- R9: If a timeout and `fsWr` fall in the same cycle, `fsOut` takes the safe code.
- R10: The safe code is applied once per timeout. Later ticks leave `fsOut` unchanged, and direct `fsWr` writes take effect again.
- R11: A restart write in the same cycle as the final tick wins. No timeout occurs, and a full `RELOAD` ticks are again needed.
- R12: The countdown advances only on cycles where `tick` is high. Cycles without a tick leave the remaining count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwrRst | input | 1 | Synchronous active-high reset derived from power-good; the strap is captured while it is high |
| strapWdEn | input | 1 | Strap that sets the enable/run bit at reset |
| tick | input | 1 | Slow count enable for the countdown |
| regWr | input | 1 | Write strobe for the control register |
| regWdata | input | 8 | Control register write data |
| regRdata | output | 8 | Control register readback {0, running, timeout, safe code} |
| fsWr | input | 1 | Direct write strobe for the frequency-select output |
| fsWdata | input | 5 | Direct write value for the frequency-select output |
| fsOut | output | 5 | Active frequency-select code |

## Verification
The bench sweeps all 32 safe codes through a full countdown. It spaces ticks with idle cycles, so a counter that counts clock cycles instead of ticks would time out early or late. In some passes a direct frequency write lands on the timeout cycle: if the priority were inverted, `fsOut` would show the direct value instead of the safe code. A restart placed on the final tick catches a design that lets the expiring count win and raises a spurious flag. Other cases cover bit 5 being written high, the strap taken at reset, and a repeat reload after timeout; a design that loads the safe code again on later ticks would overwrite a later direct write.

// File: rtl/safeclk_wd_pkg.sv
`timescale 1ns/1ps
package safeclk_wd_pkg;
  localparam int REG_W   = 8;
  localparam int FS_W    = 5;
  localparam int RUN_BIT = 6;
  localparam int TO_BIT  = 5;

  typedef struct packed {
    logic restart;
    logic halt;
    logic writeSafe;
    logic timeout;
  } wdStrobe_t;
endpackage

// File: rtl/safeclk_wd_ctrl.sv
`timescale 1ns/1ps
module safeclk_wd_ctrl
  import safeclk_wd_pkg::*;
#(
  parameter int RELOAD = 1023
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strapEn,
  input  logic             tick,
  input  logic             regWr,
  input  logic [REG_W-1:0] regWdata,
  output logic             running,
  output wdStrobe_t        strobe
);
  localparam int CW = (RELOAD < 1) ? 1 : $clog2(RELOAD + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(RELOAD);
  localparam logic [CW-1:0] LAST_VAL = CW'(1);

  logic [CW-1:0] remain;
  logic          lastTick;

  assign lastTick = running && tick && (remain == LAST_VAL);

  always_comb begin
    strobe.restart   = regWr && regWdata[RUN_BIT];
    strobe.halt      = regWr && !regWdata[RUN_BIT];
    strobe.writeSafe = regWr;
    strobe.timeout   = lastTick && !regWr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= strapEn;
      remain  <= strapEn ? LOAD_VAL : '0;
    end else if (strobe.restart) begin
      running <= 1'b1;
      remain  <= LOAD_VAL;
    end else if (strobe.halt) begin
      running <= 1'b0;
      remain  <= '0;
    end else if (running && tick) begin
      remain <= remain - LAST_VAL;
      if (remain == LAST_VAL) running <= 1'b0;
    end
  end

  p_restart_load_r2: assert property (@(posedge clk) disable iff (rst)
    strobe.restart |=> (running && remain == LOAD_VAL));
  p_timeout_stops_r3: assert property (@(posedge clk) disable iff (rst)
    strobe.timeout |=> !running);
  p_count_range_r3: assert property (@(posedge clk) disable iff (rst)
    remain <= LOAD_VAL);
  p_idle_empty_r5: assert property (@(posedge clk) disable iff (rst)
    !running |-> remain == '0);
  p_hold_no_tick_r12: assert property (@(posedge clk) disable iff (rst)
    (running && !tick && !regWr) |=> $stable(remain));
endmodule

// File: rtl/safeclk_wd_datapath.sv
`timescale 1ns/1ps
module safeclk_wd_datapath
  import safeclk_wd_pkg::*;
#(
  parameter logic [FS_W-1:0] FS_INIT = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  wdStrobe_t        strobe,
  input  logic             running,
  input  logic [REG_W-1:0] regWdata,
  input  logic             fsWr,
  input  logic [FS_W-1:0]  fsWdata,
  output logic [FS_W-1:0]  fsOut,
  output logic [REG_W-1:0] regRdata
);
  logic            toFlag;
  logic [FS_W-1:0] safeCode;

  always_ff @(posedge clk) begin
    if (rst)                  toFlag <= 1'b0;
    else if (strobe.restart)  toFlag <= 1'b0;
    else if (strobe.timeout)  toFlag <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                   safeCode <= '0;
    else if (strobe.writeSafe) safeCode <= regWdata[FS_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)                 fsOut <= FS_INIT;
    else if (strobe.timeout) fsOut <= safeCode;
    else if (fsWr)           fsOut <= fsWdata;
  end

  assign regRdata = {1'b0, running, toFlag, safeCode};

  p_flag_rise_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(toFlag) |-> $past(strobe.timeout));
  p_fs_load_r4: assert property (@(posedge clk) disable iff (rst)
    strobe.timeout |=> fsOut == $past(safeCode));
  p_flag_clear_r2: assert property (@(posedge clk) disable iff (rst)
    strobe.restart |=> !toFlag);
  p_flag_ro_r6: assert property (@(posedge clk) disable iff (rst)
    (!strobe.restart && !strobe.timeout) |=> $stable(toFlag));
  p_fs_once_r10: assert property (@(posedge clk) disable iff (rst)
    (!strobe.timeout && !fsWr) |=> $stable(fsOut));
endmodule

// File: rtl/safeclk_watchdog.sv
`timescale 1ns/1ps
module safeclk_watchdog
  import safeclk_wd_pkg::*;
#(
  parameter int              RELOAD  = 1023,
  parameter logic [FS_W-1:0] FS_INIT = '0
) (
  input  logic             clk,
  input  logic             pwrRst,
  input  logic             strapWdEn,
  input  logic             tick,
  input  logic             regWr,
  input  logic [REG_W-1:0] regWdata,
  output logic [REG_W-1:0] regRdata,
  input  logic             fsWr,
  input  logic [FS_W-1:0]  fsWdata,
  output logic [FS_W-1:0]  fsOut
);
  wdStrobe_t strobe;
  logic      running;

  safeclk_wd_ctrl #(.RELOAD(RELOAD)) u_ctrl (
    .clk(clk), .rst(pwrRst), .strapEn(strapWdEn), .tick(tick),
    .regWr(regWr), .regWdata(regWdata), .running(running), .strobe(strobe)
  );

  safeclk_wd_datapath #(.FS_INIT(FS_INIT)) u_dp (
    .clk(clk), .rst(pwrRst), .strobe(strobe), .running(running),
    .regWdata(regWdata), .fsWr(fsWr), .fsWdata(fsWdata),
    .fsOut(fsOut), .regRdata(regRdata)
  );

  p_bit7_zero_r7: assert property (@(posedge clk) disable iff (pwrRst)
    regRdata[7] == 1'b0);
endmodule

// File: tb/safeclk_watchdog_bench.sv
`timescale 1ns/1ps
module safeclk_watchdog_bench;
  localparam int RL = 5;
  localparam logic [4:0] FSI = 5'd0;

  logic clk = 1'b0;
  logic pwrRst = 1'b1, strapWdEn = 1'b0, tick = 1'b0, regWr = 1'b0, fsWr = 1'b0;
  logic [7:0] regWdata = '0;
  logic [4:0] fsWdata = '0;
  logic [7:0] regRdata;
  logic [4:0] fsOut;
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  safeclk_watchdog #(.RELOAD(RL), .FS_INIT(FSI)) u_safeclk_watchdog (
    .clk(clk), .pwrRst(pwrRst), .strapWdEn(strapWdEn), .tick(tick),
    .regWr(regWr), .regWdata(regWdata), .regRdata(regRdata),
    .fsWr(fsWr), .fsWdata(fsWdata), .fsOut(fsOut)
  );

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one cycle: inputs set after a falling edge, outputs read at the next falling edge
  task automatic step(bit wr, logic [7:0] wd, bit tk, bit fw, logic [4:0] fd);
    regWr = wr; regWdata = wd; tick = tk; fsWr = fw; fsWdata = fd;
    @(negedge clk);
    regWr = 0; regWdata = '0; tick = 0; fsWr = 0; fsWdata = '0;
  endtask

  task automatic doReset(bit strap);
    strapWdEn = strap; pwrRst = 1;
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    pwrRst = 0; strapWdEn = 0;
  endtask

  initial begin
    #1ms;
    nFails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1 with strap 0
    doReset(0);
    check("R1 rdata", regRdata, 8'h00);
    check("R1 fsOut", fsOut, FSI);
    for (int i = 0; i < 8; i++) step(0, 0, 1, 0, 0);
    check("R5 idle no timeout", regRdata, 8'h00);

    // exhaustive sweep of safe codes
    for (int code = 0; code < 32; code++) begin
      logic [4:0] other;
      other = ~code[4:0];
      step(0, 0, 0, 1, other);
      check("R8 direct write", fsOut, other);
      step(1, {3'b011, code[4:0]}, 0, 0, 0);
      check("R2/R6 restart rdata", regRdata, {3'b010, code[4:0]});
      for (int t = 0; t < RL - 1; t++) begin
        step(0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 0);
      end
      check("R3/R12 still running", regRdata, {3'b010, code[4:0]});
      check("R3 fsOut unchanged", fsOut, other);
      if (code % 4 == 2) step(0, 0, 1, 1, 5'h11);
      else step(0, 0, 1, 0, 0);
      check("R3 timeout rdata", regRdata, {3'b001, code[4:0]});
      check((code % 4 == 2) ? "R9 timeout over direct" : "R4 safe load", fsOut, code);
      for (int t = 0; t < 3; t++) step(0, 0, 1, 0, 0);
      check("R10 no reload", fsOut, code);
      check("R7 bit7", regRdata[7], 0);
      if (code % 2 == 1) begin
        step(0, 0, 1, 1, 5'h15);
        check("R10 direct after timeout", fsOut, 5'h15);
      end
    end

    // restart after timeout clears flag
    step(1, 8'hC9, 0, 0, 0);
    check("R2 flag cleared, R7 bit7", regRdata, 8'h49);

    // halt
    step(0, 0, 1, 0, 0);
    step(0, 0, 1, 0, 0);
    step(0, 0, 1, 1, 5'h03);
    step(1, 8'h27, 0, 0, 0);
    check("R5 halt rdata", regRdata, 8'h07);
    for (int t = 0; t < 2 * RL; t++) step(0, 0, 1, 0, 0);
    check("R5 no timeout", regRdata, 8'h07);
    check("R5 fsOut kept", fsOut, 5'h03);

    // restart mid count
    step(1, 8'h4A, 0, 0, 0);
    for (int t = 0; t < 3; t++) step(0, 0, 1, 0, 0);
    step(1, 8'h4A, 0, 0, 0);
    for (int t = 0; t < RL - 1; t++) step(0, 0, 1, 0, 0);
    check("R2 reload mid count", regRdata, 8'h4A);
    step(0, 0, 1, 0, 0);
    check("R3 timeout after reload", regRdata, 8'h2A);
    check("R4 safe load", fsOut, 5'h0A);

    // restart on final tick
    step(0, 0, 0, 1, 5'h1F);
    step(1, 8'h44, 0, 0, 0);
    for (int t = 0; t < RL - 1; t++) step(0, 0, 1, 0, 0);
    step(1, 8'h44, 1, 0, 0);
    check("R11 restart wins", regRdata, 8'h44);
    check("R11 fsOut kept", fsOut, 5'h1F);
    for (int t = 0; t < RL - 1; t++) step(0, 0, 1, 0, 0);
    check("R11 full count again", regRdata, 8'h44);
    step(0, 0, 1, 0, 0);
    check("R11 later timeout", regRdata, 8'h24);

    // R1 with strap 1
    step(0, 0, 0, 1, 5'h09);
    doReset(1);
    check("R1 strap rdata", regRdata, 8'h40);
    check("R1 fsOut", fsOut, FSI);
    step(0, 0, 0, 1, 5'h09);
    for (int t = 0; t < RL - 1; t++) step(0, 0, 1, 0, 0);
    check("R1 strap running", regRdata, 8'h40);
    step(0, 0, 1, 0, 0);
    check("R1 strap timeout", regRdata, 8'h20);
    check("R4 zero safe code", fsOut, 5'h00);

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    finished = 1;
    $finish;
  end
endmodule